// File: doc/BRIEF.md
# Selectable-Rate Digital Pin Noise Eliminator

This block cleans up one external interrupt pin before it reaches interrupt logic. The pin is first brought into the main clock domain by a synchronizer chain. It then takes one of two paths. The first is a plain pass-through of the synchronized level. The second is a digital filter that samples the pin on slow sampling strobes and changes its output level only when three consecutive samples agree. A transition detector on the filtered level emits a one-cycle interrupt request on the rising edge, the falling edge, both edges, or neither.

The sampling strobe comes from a prescaler on the main clock, which divides by 64, 128, 256, 512 or 1024. It can instead come from a subclock strobe that the surrounding logic has already synchronized into the main clock domain. Software sets the path and the rate through one 8-bit control register. When the rate code changes, the prescaler restarts and the filter waits for three fresh samples before its output may move again. The block has no streaming data path. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure rule.

Top module: `pin_noise_filter`

## Requirements
- R1: After reset the control register reads 0x00, `filt_out` is 0 and `irq` is 0.
- R2: A write stores bit 7 as the filter enable and bits 2..0 as the rate code. Bits 6..3 always read as zero, so writing 0xFF reads back 0x87.
- R3: With the enable bit at 0, `filt_out` follows `pin_in` three main-clock cycles after the pin changes. Pulses of any width pass, including short ones.
- R4: With the enable bit at 1, `filt_out` changes only on a sampling strobe, and only when the newest sample and the two before it all have the new level. A level held for at least three sampling periods reaches `filt_out`.
- R5: With the enable bit at 1, a pulse shorter than two sampling periods never reaches `filt_out` or `irq`, whatever its phase against the strobes.
- R6: The rate codes are 000=/64, 001=/128, 010=/256, 011=/512 and 100=/1024 of the main clock, and 101 selects the `sub_tick` strobe. Under code 101 the filter samples only on cycles where `sub_tick` is high.
- R7: Rate codes 110 and 111 produce no sampling strobes, so with the enable bit at 1 `filt_out` holds its last value.
- R8: `edge_sel` encodes 00=none, 01=rising, 10=falling and 11=both. `irq` is high for exactly one main-clock cycle after each selected transition of `filt_out`, and is never high while `edge_sel` is 00.
- R9: A write that changes the rate code restarts the prescaler in the cycle of the write. The filter output then cannot change before the third strobe after that write. For /128 that strobe lands exactly 384 cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| sub_tick | input | 1 | Subclock strobe, one main-clock cycle wide, already synchronized |
| pin_in | input | 1 | Raw asynchronous interrupt pin |
| edge_sel | input | 2 | Transition select for the request |
| filt_out | output | 1 | Filtered pin level |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `sub_tick` is already a one-cycle strobe in the main clock domain. They also assume that `edge_sel` and the control register change only while no filtered transition is pending. The bench drives every input on the falling clock edge and pulses `sub_tick` for single cycles with gaps between them. It changes `edge_sel` only after the filtered level has settled. The rate-hold properties read the register state from `cfg_rdata` and exclude write cycles, so a write never sits inside the window they check.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RATE_DIV64   = 3'd0,
    RATE_DIV128  = 3'd1,
    RATE_DIV256  = 3'd2,
    RATE_DIV512  = 3'd3,
    RATE_DIV1024 = 3'd4,
    RATE_SUB     = 3'd5,
    RATE_BAD6    = 3'd6,
    RATE_BAD7    = 3'd7
  } rate_e;

  typedef struct packed {
    logic  dig_en;
    rate_e rate;
  } cfg_t;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;
endpackage

// File: rtl/pnf_prescaler.sv
module pnf_prescaler
  import pnf_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int NUM_DIVS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] rate,
  input  logic             sub_tick,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG2 + NUM_DIVS - 1;

  logic [CNT_W-1:0]    cnt;
  logic [NUM_DIVS-1:0] hit;

  // A divider of 2^k strikes when the low k bits are all ones
  for (genvar g = 0; g < NUM_DIVS; g++) begin : g_hit
    assign hit[g] = &cnt[BASE_LOG2+g-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_DIVS; i++) begin
      if (rate == SEL_W'(i)) tick = hit[i];
    end
    if (rate == SEL_W'(NUM_DIVS)) tick = sub_tick;
  end
endmodule

// File: rtl/pnf_sampler.sv
module pnf_sampler #(
  parameter int SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic pin,
  input  logic bypass,
  output logic level
);
  localparam int PRIME_MAX = SAMPLES - 1;
  localparam int PRIME_W   = $clog2(SAMPLES);

  logic [SAMPLES-2:0] hist;
  logic [SAMPLES-1:0] window;
  logic [PRIME_W-1:0] prime;
  logic               primed;
  logic               agree;

  assign window = {hist, pin};
  assign agree  = (&window) | ~(|window);
  assign primed = (prime == PRIME_W'(PRIME_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      prime <= '0;
      level <= 1'b0;
    end else begin
      if (tick) hist <= window[SAMPLES-2:0];
      if (restart)              prime <= '0;
      else if (tick && !primed) prime <= prime + 1'b1;
      if (bypass)                        level <= pin;
      else if (tick && primed && agree)  level <= pin;
    end
  end
endmodule

// File: rtl/pnf_edge.sv
module pnf_edge
  import pnf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic [1:0] edge_sel,
  output logic       irq
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign irq = (level & ~prev & edge_sel[0]) | (~level & prev & edge_sel[1]);
endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter
  import pnf_pkg::*;
#(
  parameter int BASE_LOG2   = 6,
  parameter int NUM_DIVS    = 5,
  parameter int SAMPLES     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       sub_tick,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       filt_out,
  output logic       irq
);
  cfg_t                   cfg;
  logic                   restart;
  logic                   samp_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{dig_en: 1'b0, rate: RATE_DIV64};
    end else if (cfg_we) begin
      cfg.dig_en <= cfg_wdata[7];
      cfg.rate   <= rate_e'(cfg_wdata[SEL_W-1:0]);
    end
  end

  assign cfg_rdata = {cfg.dig_en, 4'b0000, cfg.rate};
  assign restart   = cfg_we && (cfg_wdata[SEL_W-1:0] != cfg.rate);

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  pnf_prescaler #(.BASE_LOG2(BASE_LOG2), .NUM_DIVS(NUM_DIVS)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .rate     (cfg.rate),
    .sub_tick (sub_tick),
    .tick     (samp_tick)
  );

  pnf_sampler #(.SAMPLES(SAMPLES)) i_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (samp_tick),
    .pin     (pin_s),
    .bypass  (!cfg.dig_en),
    .level   (filt_out)
  );

  pnf_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (filt_out),
    .edge_sel (edge_sel),
    .irq      (irq)
  );
endmodule

// File: rtl/pnf_checker.sv
module pnf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       sub_tick,
  input logic [1:0] edge_sel,
  input logic       filt_out,
  input logic       irq,
  input logic       samp_tick
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:3] == 4'b0000); // R2

  AST_DIG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && !cfg_we && !samp_tick) |=> $stable(filt_out)); // R4

  AST_SUB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && cfg_rdata[2:0] == 3'b101 && !cfg_we && !sub_tick) |=> $stable(filt_out)); // R6

  AST_PROHIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && cfg_rdata[2:1] == 2'b11 && !cfg_we) |=> $stable(filt_out)); // R7

  AST_IRQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_sel != 2'b00)); // R8
endmodule

bind pin_noise_filter pnf_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .sub_tick  (sub_tick),
  .edge_sel  (edge_sel),
  .filt_out  (filt_out),
  .irq       (irq),
  .samp_tick (samp_tick)
);

// File: tb/test_pin_noise_filter.sv
`timescale 1ns/1ps
module test_pin_noise_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sub_tick = 1'b0;
  logic       pin_in = 1'b0;
  logic [1:0] edge_sel = 2'b11;
  logic       filt_out;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_noise_filter i_pin_noise_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sub_tick(sub_tick), .pin_in(pin_in),
    .edge_sel(edge_sel), .filt_out(filt_out), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
    chk(filt_out == 1'b0, "R1 filt_out", filt_out, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    wr(8'hFF);
    chk(cfg_rdata == 8'h87, "R2 reserved bits", cfg_rdata, 8'h87);
    wr(8'h00);
    chk(cfg_rdata == 8'h00, "R2 clear", cfg_rdata, 0);
  endtask

  task automatic t_bypass;
    int base;
    edge_sel = 2'b11; base = irq_cnt;
    pin_in = 1'b1;
    cyc(3);
    chk(filt_out == 1'b1, "R3 follows after 3", filt_out, 1);
    cyc(5);
    pin_in = 1'b0; cyc(10);
    chk(filt_out == 1'b0, "R3 back low", filt_out, 0);
    pin_in = 1'b1; cyc(1); pin_in = 1'b0; cyc(10);
    chk(irq_cnt - base == 4, "R3 short pulse passes", irq_cnt - base, 4);
  endtask

  task automatic t_digital;
    int base;
    wr(8'h80); edge_sel = 2'b01; base = irq_cnt;
    pin_in = 1'b1; cyc(300);
    chk(filt_out == 1'b1, "R4 long high passes", filt_out, 1);
    pin_in = 1'b0; cyc(300);
    chk(filt_out == 1'b0, "R4 long low passes", filt_out, 0);
    chk(irq_cnt - base == 1, "R8 rising only", irq_cnt - base, 1);
  endtask

  task automatic t_reject;
    int base;
    edge_sel = 2'b11;
    for (int k = 0; k < 3; k++) begin
      cyc(k * 17 + 5);
      base = irq_cnt;
      pin_in = 1'b1; cyc(100); pin_in = 1'b0; cyc(300);
      chk(filt_out == 1'b0, "R5 narrow pulse level", filt_out, 0);
      chk(irq_cnt == base, "R5 narrow pulse irq", irq_cnt - base, 0);
    end
  endtask

  task automatic t_rates;
    wr(8'h84); cyc(3200);
    pin_in = 1'b1; cyc(1500); pin_in = 1'b0; cyc(3200);
    chk(filt_out == 1'b0, "R6 div1024 rejects 1500", filt_out, 0);
    pin_in = 1'b1; cyc(3500);
    chk(filt_out == 1'b1, "R6 div1024 passes 3500", filt_out, 1);
    pin_in = 1'b0; cyc(3500);
    chk(filt_out == 1'b0, "R6 div1024 back low", filt_out, 0);
  endtask

  task automatic t_subclock;
    wr(8'h85);
    pin_in = 1'b1; cyc(2000);
    chk(filt_out == 1'b0, "R6 no sub_tick no change", filt_out, 0);
    for (int k = 0; k < 5; k++) begin
      sub_tick = 1'b1; cyc(1); sub_tick = 1'b0; cyc(9);
    end
    chk(filt_out == 1'b1, "R6 sub_tick samples", filt_out, 1);
  endtask

  task automatic t_prohibited;
    pin_in = 1'b0; wr(8'h80); cyc(300);
    chk(filt_out == 1'b0, "R7 setup low", filt_out, 0);
    wr(8'h86);
    chk(cfg_rdata == 8'h86, "R7 code stored", cfg_rdata, 8'h86);
    pin_in = 1'b1; cyc(2000);
    chk(filt_out == 1'b0, "R7 output held", filt_out, 0);
    pin_in = 1'b0; cyc(10);
  endtask

  task automatic t_edges;
    int base;
    int exp;
    wr(8'h00); cyc(10);
    for (int es = 0; es < 4; es++) begin
      edge_sel = 2'(es); base = irq_cnt;
      pin_in = 1'b1; cyc(10); pin_in = 1'b0; cyc(10);
      exp = (es == 0) ? 0 : (es == 3) ? 2 : 1;
      chk(irq_cnt - base == exp, "R8 edge select count", irq_cnt - base, exp);
    end
    edge_sel = 2'b11;
  endtask

  task automatic t_reinit;
    wr(8'h80); cyc(300);
    chk(filt_out == 1'b0, "R9 setup low", filt_out, 0);
    @(negedge clk);
    pin_in = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h81;
    @(negedge clk);
    cfg_we = 1'b0;
    cyc(378);
    chk(filt_out == 1'b0, "R9 before third strobe", filt_out, 0);
    cyc(10);
    chk(filt_out == 1'b1, "R9 after third strobe", filt_out, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_regs();
    t_bypass();
    t_digital();
    t_reject();
    t_rates();
    t_subclock();
    t_prohibited();
    t_edges();
    t_reinit();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule